// File: doc/BRIEF.md
# DRAM Activate Window Limiter

This block watches the row-activate traffic of one DRAM channel and keeps it under a rolling cap. The cap allows at most a fixed number of activates in any window of a given number of cycles. The block keeps the most recent activate timestamps in a short history. Each time the scheduler records an access, the block derives the activate time from the bank's free time. The formula depends on the page policy, which is chosen by a parameter.

When the history shows that the window is crowded, the block publishes a floor time. All banks must hold their next activate until that time. The block also flags any incoming activate that already breaks the window. Timestamps are unsigned counts of a parameter width. The value zero marks an unused history slot. The logic assumes that timestamps do not wrap within one window.

The scheduler drives `rec_vld` for one cycle with the bank free time. All results are registered and appear one cycle later.

Top module: `act_window_guard`

## Requirements
- R1: After reset, every history slot is zero, `floor_time` is 0, and `viol` and `throttle` are low.
- R2: With `OPEN_PAGE`=1, the activate time is `bank_free` - `T_CL` - `T_RCD`. It appears on `act_time` in the cycle after the strobe.
- R3: With `OPEN_PAGE`=0, the activate time is `bank_free` - 2·`T_RP` - `T_CL` - `T_RCD`. It appears on `act_time` in the cycle after the strobe.
- R4: The oldest history entry is checked before the new time is inserted. If it is nonzero and (new time - oldest) < `WIN`, `viol` is high in the cycle after the strobe.
- R5: A zero history slot takes part in neither the violation check nor the throttle check. Before the history holds `NACT` activates, neither flag rises.
- R6: The oldest entry is checked again after insertion. If it is nonzero and (new time - it) < `WIN`, `throttle` pulses. `floor_time` then becomes the larger of its old value and that entry + `WIN`. Both changes appear one cycle after the strobe.
- R7: `floor_time` changes only in a cycle where `throttle` is high, and it never decreases.
- R8: `viol` and `throttle` are single-cycle results. They are low in any cycle that follows a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_vld | input | 1 | Records one activate this cycle |
| bank_free | input | TW | Free time of the accessed bank |
| act_time | output | TW | Most recent derived activate time |
| viol | output | 1 | The recorded activate broke the window |
| throttle | output | 1 | The window is now full and the floor was updated |
| floor_time | output | TW | Earliest next activate allowed for every bank |

## Verification
The violation check and the throttle check can fire on the same strobe. The first compares against the entry that is about to be dropped. The second compares against the entry that becomes oldest. The bench provokes this by filling the history with four closely spaced activates and then sending a fifth inside the window. It then expects `viol` and `throttle` together, with the floor moved to the second-oldest time plus the window. A later burst repeats the overlap after a long gap, so that the floor has to jump upward from a stale value.

// File: rtl/act_window_guard.sv
module act_window_guard #(
  parameter int TW        = 16,
  parameter int NACT      = 4,
  parameter int WIN       = 40,
  parameter int T_CL      = 3,
  parameter int T_RCD     = 4,
  parameter int T_RP      = 5,
  parameter bit OPEN_PAGE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_vld,
  input  logic [TW-1:0] bank_free,
  output logic [TW-1:0] act_time,
  output logic          viol,
  output logic          throttle,
  output logic [TW-1:0] floor_time
);

  localparam logic [TW-1:0] WIN_W = TW'(WIN);

  logic [TW-1:0] backoff;
  logic [TW-1:0] new_t;
  logic [TW-1:0] hist   [NACT];
  logic [TW-1:0] hist_n [NACT];
  logic [TW-1:0] old_pre, old_post, cand, raised;
  logic          pre_hit, post_hit;

  generate
    if (OPEN_PAGE) begin : g_open
      assign backoff = TW'(T_CL + T_RCD);
    end else begin : g_closed
      assign backoff = TW'(2 * T_RP + T_CL + T_RCD);
    end
  endgenerate

  assign new_t = bank_free - backoff;

  always_comb begin
    hist_n[0] = new_t;
    for (int i = 1; i < NACT; i++) hist_n[i] = hist[i-1];
  end

  assign old_pre  = hist[NACT-1];
  assign old_post = hist_n[NACT-1];
  assign pre_hit  = (old_pre  != '0) && ((new_t - old_pre)  < WIN_W);
  assign post_hit = (old_post != '0) && ((new_t - old_post) < WIN_W);
  assign cand     = old_post + WIN_W;
  assign raised   = (cand > floor_time) ? cand : floor_time;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NACT; i++) hist[i] <= '0;
      act_time   <= '0;
      viol       <= 1'b0;
      throttle   <= 1'b0;
      floor_time <= '0;
    end else if (rec_vld) begin
      for (int i = 0; i < NACT; i++) hist[i] <= hist_n[i];
      act_time <= new_t;
      viol     <= pre_hit;
      throttle <= post_hit;
      if (post_hit) floor_time <= raised;
    end else begin
      viol     <= 1'b0;
      throttle <= 1'b0;
    end
  end

endmodule

module act_window_guard_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rec_vld,
  input logic [TW-1:0] act_time,
  input logic          viol,
  input logic          throttle,
  input logic [TW-1:0] floor_time
);

  assert_flags_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_vld |=> (!viol && !throttle));

  assert_floor_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
    floor_time >= $past(floor_time));

  assert_floor_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(floor_time) |-> throttle);

  assert_floor_ahead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    throttle |-> (floor_time > act_time));

  assert_viol_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(rec_vld));

endmodule

bind act_window_guard act_window_guard_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_vld(rec_vld), .act_time(act_time),
  .viol(viol), .throttle(throttle), .floor_time(floor_time)
);

// File: tb/test_act_window_guard.sv
`timescale 1ns/1ps
module test_act_window_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_vld = 1'b0;
  logic [15:0] bank_free = '0;
  logic [15:0] act_o, floor_o, act_c, floor_c;
  logic        viol_o, thr_o, viol_c, thr_c;

  always #2 clk = ~clk;

  act_window_guard i_act_window_guard (
    .clk(clk), .rst_n(rst_n), .rec_vld(rec_vld), .bank_free(bank_free),
    .act_time(act_o), .viol(viol_o), .throttle(thr_o), .floor_time(floor_o));

  act_window_guard #(.OPEN_PAGE(1'b0)) i_act_window_guard_cp (
    .clk(clk), .rst_n(rst_n), .rec_vld(rec_vld), .bank_free(bank_free),
    .act_time(act_c), .viol(viol_c), .throttle(thr_c), .floor_time(floor_c));

  typedef struct {
    logic [15:0] act_o;
    logic [15:0] act_c;
    logic        viol;
    logic        thr;
    logic [15:0] floor;
    bit          idle;
    bit          warm;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  logic [15:0] mh [4];
  logic [15:0] m_floor = '0, m_act_o = '0, m_act_c = '0;
  bit done = 0;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic act(input logic [15:0] t);
    exp_t e;
    logic [15:0] f;
    f = t + 16'd7;
    @(negedge clk);
    rec_vld = 1'b1;
    bank_free = f;
    e.warm = (mh[3] == 0);
    e.viol = (mh[3] != 0) && ((t - mh[3]) < 16'd40);
    for (int i = 3; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = t;
    e.thr = (mh[3] != 0) && ((t - mh[3]) < 16'd40);
    if (e.thr && (mh[3] + 16'd40 > m_floor)) m_floor = mh[3] + 16'd40;
    m_act_o = f - 16'd7;
    m_act_c = f - 16'd17;
    e.act_o = m_act_o; e.act_c = m_act_c; e.floor = m_floor; e.idle = 0;
    q.push_back(e);
  endtask

  task automatic idle();
    exp_t e;
    @(negedge clk);
    rec_vld = 1'b0;
    e.act_o = m_act_o; e.act_c = m_act_c; e.viol = 0; e.thr = 0;
    e.floor = m_floor; e.idle = 1; e.warm = 0;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R2 open act_time", act_o, e.act_o);
      chk("R3 closed act_time", act_c, e.act_c);
      chk(e.idle ? "R8 viol idle" : (e.warm ? "R5 viol warm" : "R4 viol"),
          {15'd0, viol_o}, {15'd0, e.viol});
      chk(e.idle ? "R8 throttle idle" : (e.warm ? "R5 throttle warm" : "R6 throttle"),
          {15'd0, thr_o}, {15'd0, e.thr});
      chk(e.idle ? "R7 floor hold" : "R6 R7 floor", floor_o, e.floor);
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mh[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 floor reset", floor_o, 16'd0);
    chk("R1 viol reset", {15'd0, viol_o}, 16'd0);
    chk("R1 throttle reset", {15'd0, thr_o}, 16'd0);
    rst_n = 1'b1;
    act(100); act(110); act(120);
    act(130);
    act(135);
    idle();
    act(300);
    idle();
    act(305); act(310);
    act(312);
    act(313);
    idle(); idle();
    @(negedge clk);
    rec_vld = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule